// File: doc/BRIEF.md
# Interrupt Controller Operating-Mode Sequencer

This block keeps track of which operating mode a local interrupt controller is in. There are three modes. In the off mode the controller is disabled. In the legacy mode it has an 8-bit identifier and its registers are reached through memory-mapped access. In the extended mode it has a 32-bit identifier. Software asks for a mode by writing an enable bit and an extend bit. The block decides whether the requested move is allowed from the current mode. An allowed move changes the mode. A forbidden move leaves the mode as it is and produces a one-cycle protection-fault pulse.

The block also handles the hardware reset and the INIT event. It drives four one-cycle clear strobes so that the register file next to it knows what to wipe. The strobes cover the identifier register, the logical destination register, the upper half of the command register and all remaining registers. The block holds the 8-bit legacy identifier and the 32-bit extended identifier itself, and it shows the identifier as software would read it in the current mode.

Top module: `irq_mode_ctrl`

## Requirements
- R1: The mode is the pair {enable, extend} and mode_o reports it: 2'b00 is off, 2'b10 is legacy and 2'b11 is extended. An accepted write changes mode_o at the first clock edge after the write.
- R2: A write that requests {enable, extend} = 2'b01 is rejected. It produces a fault pulse and the mode does not change.
- R3: From extended mode, a write that requests legacy is rejected with a fault. A write that requests off is accepted, and both the legacy ID and the extended ID keep their values.
- R4: From off mode, a write that requests legacy is accepted. A write that requests extended is rejected with a fault.
- R5: An accepted move from legacy to extended pulses clr_ldr_o and clr_icrh_o, leaves clr_id_o and clr_misc_o low, and restores the legacy ID to the hardware value HW_XID[7:0].
- R6: A hardware reset (rst high) sets the mode to legacy, raises all four clear strobes, loads the legacy ID with HW_XID[7:0] and the extended ID with HW_XID, and holds fault_o low. Reset wins over INIT and over a mode write in the same cycle.
- R7: An INIT in legacy or extended mode keeps the mode and both IDs. It pulses clr_ldr_o, clr_icrh_o and clr_misc_o, and clr_id_o stays low.
- R8: An INIT in off mode keeps the mode at off and raises no strobe.
- R9: A write that requests the current mode is legal. It raises no fault and no strobe and changes nothing.
- R10: fault_o is high for exactly the one cycle that follows each rejected write. It is low after any write that is accepted.
- R11: A mode write in the same cycle as an INIT is ignored: no fault, and no mode change.
- R12: An ID write takes effect only in legacy mode, and only when there is no reset, no INIT and no accepted mode change in that cycle. id_view_o shows {legacy ID, 24'h0} in off and legacy mode and the extended ID in extended mode.
- R13: An accepted move into off mode from legacy or from extended pulses clr_ldr_o, clr_icrh_o and clr_misc_o, and clr_id_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset event |
| init_i | input | 1 | INIT event, sampled for one cycle |
| mode_wr_i | input | 1 | Mode write strobe |
| mode_en_i | input | 1 | Requested enable bit |
| mode_extd_i | input | 1 | Requested extend bit |
| id_wr_i | input | 1 | Software write to the legacy ID |
| id_wdata_i | input | LID_W | Legacy ID write data |
| mode_o | output | 2 | Current mode as {enable, extend} |
| fault_o | output | 1 | Protection-fault pulse for a rejected write |
| clr_id_o | output | 1 | Clear strobe for the ID register |
| clr_ldr_o | output | 1 | Clear strobe for the logical destination register |
| clr_icrh_o | output | 1 | Clear strobe for the upper half of the command register |
| clr_misc_o | output | 1 | Clear strobe for all other registers |
| lid_o | output | LID_W | Legacy identifier |
| xid_o | output | XID_W | Extended identifier |
| id_view_o | output | XID_W | Identifier as seen in the current mode |

## Verification
The hardest case to reach is dropping a software-written legacy ID on the move into extended mode. To reach it, software must first write a non-hardware ID while in legacy mode, then make the move, then come back through off mode to legacy. This is the only point at which the restored hardware value shows up in the legacy view. The stimulus follows that exact path. It also places a write in the same cycle as an INIT, and a write in the same cycle as reset plus INIT, because those priority cases occur only when several inputs coincide. Two bad writes in a row check that fault_o stays high for both cycles instead of being stretched or merged.

// File: rtl/irq_mode_pkg.sv
package irq_mode_pkg;
  typedef logic [1:0] mode_t;
  localparam mode_t MODE_OFF = 2'b00;
  localparam mode_t MODE_BAD = 2'b01;
  localparam mode_t MODE_LEG = 2'b10;
  localparam mode_t MODE_EXT = 2'b11;
endpackage

// File: rtl/irq_mode_legal.sv
module irq_mode_legal
  import irq_mode_pkg::*;
(
  input  mode_t cur_i,
  input  mode_t req_i,
  output logic  legal_o,
  output logic  same_o
);
  always_comb begin
    same_o  = (cur_i == req_i);
    legal_o = 1'b1;
    if (req_i == MODE_BAD)
      legal_o = 1'b0;
    else if (cur_i == MODE_OFF && req_i == MODE_EXT)
      legal_o = 1'b0;
    else if (cur_i == MODE_EXT && req_i == MODE_LEG)
      legal_o = 1'b0;
  end
endmodule

// File: rtl/irq_mode_fsm.sv
module irq_mode_fsm
  import irq_mode_pkg::*;
(
  input  logic  clk,
  input  logic  rst,
  input  logic  init_i,
  input  logic  wr_i,
  input  mode_t req_i,
  input  logic  legal_i,
  input  logic  same_i,
  output mode_t mode_o,
  output logic  fault_o,
  output logic  clr_id_o,
  output logic  clr_ldr_o,
  output logic  clr_icrh_o,
  output logic  clr_misc_o,
  output logic  chg_o,
  output logic  enter_ext_o
);
  mode_t mode_q;
  logic  fault_q;
  logic  c_id_q, c_ldr_q, c_icrh_q, c_misc_q;

  assign chg_o       = !rst && !init_i && wr_i && legal_i && !same_i;
  assign enter_ext_o = chg_o && (req_i == MODE_EXT);

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q   <= MODE_LEG;
      fault_q  <= 1'b0;
      c_id_q   <= 1'b1;
      c_ldr_q  <= 1'b1;
      c_icrh_q <= 1'b1;
      c_misc_q <= 1'b1;
    end else begin
      fault_q  <= 1'b0;
      c_id_q   <= 1'b0;
      c_ldr_q  <= 1'b0;
      c_icrh_q <= 1'b0;
      c_misc_q <= 1'b0;
      if (init_i) begin
        if (mode_q != MODE_OFF) begin
          c_ldr_q  <= 1'b1;
          c_icrh_q <= 1'b1;
          c_misc_q <= 1'b1;
        end
      end else if (wr_i) begin
        if (!legal_i) begin
          fault_q <= 1'b1;
        end else if (!same_i) begin
          mode_q <= req_i;
          if (req_i == MODE_OFF) begin
            c_ldr_q  <= 1'b1;
            c_icrh_q <= 1'b1;
            c_misc_q <= 1'b1;
          end else if (req_i == MODE_EXT) begin
            c_ldr_q  <= 1'b1;
            c_icrh_q <= 1'b1;
          end
        end
      end
    end
  end

  assign mode_o     = mode_q;
  assign fault_o    = fault_q;
  assign clr_id_o   = c_id_q;
  assign clr_ldr_o  = c_ldr_q;
  assign clr_icrh_o = c_icrh_q;
  assign clr_misc_o = c_misc_q;

  assert_bad_code_faults_R2: assert property (@(posedge clk) disable iff (rst)
    (wr_i && !init_i && req_i == MODE_BAD) |=> (fault_q && $stable(mode_q)));
  assert_ext_never_to_leg_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_EXT) |=> (mode_q != MODE_LEG));
  assert_off_never_to_ext_R4: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MODE_OFF) |=> (mode_q != MODE_EXT));
  assert_init_holds_mode_R11: assert property (@(posedge clk) disable iff (rst)
    init_i |=> $stable(mode_q));
  assert_fault_no_strobe_R10: assert property (@(posedge clk) disable iff (rst)
    fault_q |-> !(c_ldr_q || c_icrh_q || c_misc_q || c_id_q));
  assert_no_id_clear_R7: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !c_id_q);
endmodule

// File: rtl/irq_mode_idregs.sv
module irq_mode_idregs
  import irq_mode_pkg::*;
#(
  parameter int LID_W = 8,
  parameter int XID_W = 32,
  parameter logic [XID_W-1:0] HW_XID = 32'hA5C3_0017
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  mode_t            mode_i,
  input  logic             chg_i,
  input  logic             enter_ext_i,
  input  logic             id_wr_i,
  input  logic [LID_W-1:0] id_wdata_i,
  output logic [LID_W-1:0] lid_o,
  output logic [XID_W-1:0] xid_o,
  output logic [XID_W-1:0] view_o
);
  localparam logic [LID_W-1:0] HW_LID = HW_XID[LID_W-1:0];
  localparam int PAD_W = XID_W - LID_W;

  logic [LID_W-1:0] lid_q;
  logic [XID_W-1:0] xid_q;
  logic [XID_W-1:0] leg_view;

  always_ff @(posedge clk) begin
    if (rst) begin
      lid_q <= HW_LID;
      xid_q <= HW_XID;
    end else if (enter_ext_i) begin
      lid_q <= HW_LID;
    end else if (id_wr_i && mode_i == MODE_LEG && !init_i && !chg_i) begin
      lid_q <= id_wdata_i;
    end
  end

  generate
    if (PAD_W > 0) begin : g_pad
      assign leg_view = {lid_q, {PAD_W{1'b0}}};
    end else begin : g_nopad
      assign leg_view = lid_q[LID_W-1 -: XID_W];
    end
  endgenerate

  assign lid_o  = lid_q;
  assign xid_o  = xid_q;
  assign view_o = (mode_i == MODE_EXT) ? xid_q : leg_view;

  assert_init_keeps_lid_R7: assert property (@(posedge clk) disable iff (rst)
    init_i |=> $stable(lid_q));
  assert_ext_entry_restores_lid_R5: assert property (@(posedge clk) disable iff (rst)
    enter_ext_i |=> (lid_q == HW_LID));
  assert_no_write_outside_leg_R12: assert property (@(posedge clk) disable iff (rst)
    (mode_i != MODE_LEG) |=> $stable(lid_q));
endmodule

// File: rtl/irq_mode_ctrl.sv
module irq_mode_ctrl
  import irq_mode_pkg::*;
#(
  parameter int LID_W = 8,
  parameter int XID_W = 32,
  parameter logic [XID_W-1:0] HW_XID = 32'hA5C3_0017
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             init_i,
  input  logic             mode_wr_i,
  input  logic             mode_en_i,
  input  logic             mode_extd_i,
  input  logic             id_wr_i,
  input  logic [LID_W-1:0] id_wdata_i,
  output logic [1:0]       mode_o,
  output logic             fault_o,
  output logic             clr_id_o,
  output logic             clr_ldr_o,
  output logic             clr_icrh_o,
  output logic             clr_misc_o,
  output logic [LID_W-1:0] lid_o,
  output logic [XID_W-1:0] xid_o,
  output logic [XID_W-1:0] id_view_o
);
  mode_t req, cur;
  logic  legal, same, chg, enter_ext;

  assign req = {mode_en_i, mode_extd_i};

  irq_mode_legal u_legal (
    .cur_i   (cur),
    .req_i   (req),
    .legal_o (legal),
    .same_o  (same)
  );

  irq_mode_fsm u_fsm (
    .clk         (clk),
    .rst         (rst),
    .init_i      (init_i),
    .wr_i        (mode_wr_i),
    .req_i       (req),
    .legal_i     (legal),
    .same_i      (same),
    .mode_o      (cur),
    .fault_o     (fault_o),
    .clr_id_o    (clr_id_o),
    .clr_ldr_o   (clr_ldr_o),
    .clr_icrh_o  (clr_icrh_o),
    .clr_misc_o  (clr_misc_o),
    .chg_o       (chg),
    .enter_ext_o (enter_ext)
  );

  irq_mode_idregs #(
    .LID_W  (LID_W),
    .XID_W  (XID_W),
    .HW_XID (HW_XID)
  ) u_ids (
    .clk         (clk),
    .rst         (rst),
    .init_i      (init_i),
    .mode_i      (cur),
    .chg_i       (chg),
    .enter_ext_i (enter_ext),
    .id_wr_i     (id_wr_i),
    .id_wdata_i  (id_wdata_i),
    .lid_o       (lid_o),
    .xid_o       (xid_o),
    .view_o      (id_view_o)
  );

  assign mode_o = cur;
endmodule

// File: tb/irq_mode_ctrl_tb.sv
`timescale 1ns/1ps
module irq_mode_ctrl_tb;
  localparam logic [31:0] HW = 32'hA5C3_0017;
  localparam int PW = 2 + 1 + 4 + 8 + 32 + 32;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rst, init, mwr, men, mext, idw;
  logic [7:0] idd;
  logic [1:0] mode;
  logic fault, cid, cldr, cicrh, cmisc;
  logic [7:0] lid;
  logic [31:0] xid, view;

  irq_mode_ctrl #(.LID_W(8), .XID_W(32), .HW_XID(HW)) u_dut (
    .clk(clk), .rst(rst), .init_i(init), .mode_wr_i(mwr), .mode_en_i(men),
    .mode_extd_i(mext), .id_wr_i(idw), .id_wdata_i(idd), .mode_o(mode),
    .fault_o(fault), .clr_id_o(cid), .clr_ldr_o(cldr), .clr_icrh_o(cicrh),
    .clr_misc_o(cmisc), .lid_o(lid), .xid_o(xid), .id_view_o(view)
  );

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;
  logic [PW-1:0] exp_q[$];
  string tag_q[$];

  logic [1:0] m_mode = 2'b10;
  logic [7:0] m_lid = HW[7:0];
  logic [31:0] m_xid = HW;

  task automatic step(input logic r, input logic i, input logic w,
                      input logic [1:0] rq, input logic iw,
                      input logic [7:0] id, input string tag);
    logic f, ci, cl, ch, cm, chg;
    logic [31:0] v;
    logic [1:0] old;
    f = 0; ci = 0; cl = 0; ch = 0; cm = 0; chg = 0;
    old = m_mode;
    if (r) begin
      m_mode = 2'b10; m_lid = HW[7:0]; m_xid = HW;
      ci = 1; cl = 1; ch = 1; cm = 1;
    end else if (i) begin
      if (m_mode != 2'b00) begin cl = 1; ch = 1; cm = 1; end
    end else begin
      if (w) begin
        if (rq == 2'b01 || (m_mode == 2'b00 && rq == 2'b11) ||
            (m_mode == 2'b11 && rq == 2'b10)) begin
          f = 1;
        end else if (rq != m_mode) begin
          chg = 1;
          if (rq == 2'b00) begin cl = 1; ch = 1; cm = 1; end
          if (rq == 2'b11) begin cl = 1; ch = 1; m_lid = HW[7:0]; end
          m_mode = rq;
        end
      end
      if (iw && old == 2'b10 && !chg) m_lid = id;
    end
    v = (m_mode == 2'b11) ? m_xid : {m_lid, 24'h0};
    rst = r; init = i; mwr = w; {men, mext} = rq; idw = iw; idd = id;
    exp_q.push_back({m_mode, f, ci, cl, ch, cm, m_lid, m_xid, v});
    tag_q.push_back(tag);
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic idle(input string tag);
    step(0, 0, 0, 2'b00, 0, 8'h00, tag);
  endtask

  task automatic wr(input logic [1:0] rq, input string tag);
    step(0, 0, 1, rq, 0, 8'h00, tag);
  endtask

  initial begin : monitor
    logic [PW-1:0] e, g;
    string t;
    forever begin
      @(posedge clk);
      #1;
      if (exp_q.size() > 0) begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        g = {mode, fault, cid, cldr, cicrh, cmisc, lid, xid, view};
        checks++;
        if (g !== e) begin
          fails++;
          $display("FAIL %s actual=%h expected=%h", t, g, e);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin : driver
    step(1, 0, 0, 2'b00, 0, 8'h00, "R6 reset state");
    step(1, 0, 0, 2'b00, 0, 8'h00, "R6 reset held");
    idle("R1 legacy after reset");
    step(0, 0, 0, 2'b00, 1, 8'h42, "R12 id write in legacy");
    wr(2'b01, "R2 bad code faults");
    idle("R10 fault drops");
    wr(2'b10, "R9 same mode write");
    wr(2'b11, "R5 legacy to extended");
    step(0, 0, 0, 2'b00, 1, 8'h55, "R12 id write ignored in extended");
    wr(2'b10, "R3 extended to legacy faults");
    step(0, 1, 0, 2'b00, 0, 8'h00, "R7 init in extended");
    wr(2'b11, "R9 same extended");
    wr(2'b00, "R13 R3 extended to off keeps ids");
    wr(2'b11, "R4 off to extended faults");
    step(0, 1, 0, 2'b00, 0, 8'h00, "R8 init in off");
    step(0, 0, 0, 2'b00, 1, 8'h66, "R12 id write ignored in off");
    wr(2'b10, "R4 off to legacy");
    step(0, 0, 0, 2'b00, 1, 8'h99, "R12 second id write");
    step(0, 1, 0, 2'b00, 0, 8'h00, "R7 init in legacy keeps id");
    step(0, 1, 1, 2'b11, 0, 8'h00, "R11 write with init ignored");
    step(0, 1, 1, 2'b01, 0, 8'h00, "R11 bad write with init no fault");
    step(0, 0, 1, 2'b11, 1, 8'h77, "R12 id write dropped on change");
    wr(2'b00, "R13 extended to off");
    wr(2'b10, "R1 back to legacy");
    wr(2'b00, "R13 legacy to off");
    wr(2'b10, "R1 legacy again");
    wr(2'b11, "R1 to extended");
    step(1, 1, 1, 2'b00, 0, 8'h00, "R6 reset wins over init and write");
    wr(2'b01, "R10 first bad write");
    wr(2'b01, "R10 second bad write");
    wr(2'b10, "R10 legal write no fault");
    idle("R1 final idle");
    idle("R1 drain");
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule